// File: doc/BRIEF.md
# Power-Stage Protection Supervisor

This block is the digital fault sequencer that sits between the sensing front end of a synchronous buck power stage and its gate-control logic. It watches a digitized supply-voltage code, a digitized junction-temperature code, an over-current comparator flag (meaningful only while the low-side switch conducts), an enable pin and a strobe marking the start of each switching period. From these it decides whether the gate logic may run at all, whether a requested switching period has to be skipped because the current is still above the valley limit, and whether a persistent over-current has to shut the stage down until software or the system power cycles it.

The supply monitor uses a rising threshold with hysteresis and filters short undershoots. The thermal monitor trips above a limit and re-arms only once the temperature has dropped by a hysteresis band. A sustained over-current sets a latch that holds both gates off and drives an active-low fault pin, modelled here as an output-enable for an open-drain pad. Every threshold, band and filter length is a parameter in code units or clock cycles.

Top module: `pstage_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `run_ok`, `cyc_skip`, `oc_latched` and `fault_oe` are all 0, whatever the other inputs do.
- R2: With the supply not yet good, one sample with `vsup_code >= V_ON` makes the supply good on the next edge, so `run_ok` (with the other conditions met) rises two cycles after that code is applied.
- R3: Once good, the supply is declared bad only after `V_DGL` consecutive samples with `vsup_code < V_ON - V_HYS`; codes inside the band `[V_ON - V_HYS, V_ON)` and dips shorter than `V_DGL` samples leave `run_ok` high.
- R4: A sample with `tj_code > T_TRIP` sets the over-temperature state on the next edge; it clears on the edge after a sample with `tj_code <= T_TRIP - T_HYS`. Codes between these keep the current state.
- R5: `run_ok` is the registered AND of supply good, not over-temperature, not over-current latched and `en`; `en` going low drops `run_ok` on the next edge and `en` going high (other conditions met) raises it on the next edge.
- R6: `cyc_skip` is high for the cycle after a sample where `cyc_start` and `oc_flag` are both 1, and low after any other sample.
- R7: While `run_ok` is high, `OC_DGL` consecutive samples with `oc_flag` = 1 set `oc_latched` on the edge of the last of them; any 0 sample restarts the count, so shorter runs leave it clear.
- R8: `oc_latched` forces `run_ok` low on the next edge and holds regardless of `oc_flag` or `en` being low; it clears on the edge after `en` rises from 0 to 1, or on the edge after the supply monitor has declared the supply bad.
- R9: `fault_oe` (1 = pull the active-low fault pin low, 0 = release it) follows `oc_latched` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsup_code | input | VW | Digitized supply voltage |
| tj_code | input | TW | Digitized junction temperature |
| oc_flag | input | 1 | Low-side current above limit |
| en | input | 1 | Enable, high runs the stage |
| cyc_start | input | 1 | Strobe requesting a new switching period |
| run_ok | output | 1 | Gate logic may switch |
| cyc_skip | output | 1 | Requested period denied by valley limit |
| oc_latched | output | 1 | Over-current shutdown latched |
| fault_oe | output | 1 | Drive the active-low fault pin low |

## Verification
The bench builds the block with 8-bit codes, `V_ON` = 200, `V_HYS` = 5, `V_DGL` = 4, `T_TRIP` = 145, `T_HYS` = 45 and `OC_DGL` = 8. The small code width lets every supply and temperature code be swept in both the rising and the falling direction, so each threshold and hysteresis edge is hit exactly, and the short filter lengths put the boundary runs (one sample short of the filter and exactly the filter) within a few cycles. Latch release is exercised both by an enable toggle and by a supply collapse.

// File: rtl/pstage_pkg.sv
package pstage_pkg;

  // Width of a counter that must hold values 0..n
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Health summary gathered from the level monitors
  typedef struct packed {
    logic sup_good;
    logic hot;
  } health_t;

endpackage

// File: rtl/hyst_det.sv
module hyst_det
  import pstage_pkg::*;
#(
  parameter int W      = 8,
  parameter int SET_AT = 200,  // level sets when x >= SET_AT
  parameter int CLR_AT = 194,  // level clears when x <= CLR_AT ...
  parameter int DGL    = 4     // ... for DGL consecutive samples
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] x,
  output logic         lvl
);
  localparam logic [W-1:0] SET_C = W'(SET_AT);
  localparam logic [W-1:0] CLR_C = W'(CLR_AT);

  logic hit_set;
  logic hit_clr;
  assign hit_set = (x >= SET_C);
  assign hit_clr = (x <= CLR_C);

  generate
    if (DGL <= 1) begin : g_fast
      always_ff @(posedge clk) begin
        if (rst) begin
          lvl <= 1'b0;
        end else if (!lvl) begin
          lvl <= hit_set;
        end else begin
          lvl <= !hit_clr;
        end
      end

      // R4: one low sample clears the level on the next edge
      a_r4_clear_now: assert property (@(posedge clk) disable iff (rst)
        lvl && hit_clr |=> !lvl);
    end else begin : g_dgl
      localparam int CW = cnt_w(DGL);
      logic [CW-1:0] low_cnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          lvl     <= 1'b0;
          low_cnt <= '0;
        end else if (!lvl) begin
          low_cnt <= '0;
          lvl     <= hit_set;
        end else if (hit_clr) begin
          if (low_cnt == CW'(DGL - 1)) begin
            lvl     <= 1'b0;
            low_cnt <= '0;
          end else begin
            low_cnt <= low_cnt + 1'b1;
          end
        end else begin
          low_cnt <= '0;
        end
      end

      // R3: filter count never passes its limit
      a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= CW'(DGL - 1));
      // R3: a first low sample alone does not clear the level
      a_r3_first_low_holds: assert property (@(posedge clk) disable iff (rst)
        lvl && hit_clr && (low_cnt == '0) |=> lvl);
    end
  endgenerate

  // R2 / R4: a sample at or past the set point sets the level
  a_r2_set: assert property (@(posedge clk) disable iff (rst)
    !lvl && hit_set |=> lvl);
  // R3 / R4: a sample above the clear point keeps a set level
  a_r3_hold_band: assert property (@(posedge clk) disable iff (rst)
    lvl && !hit_clr |=> lvl);
  // R2: below the set point a clear level stays clear
  a_r2_stay_low: assert property (@(posedge clk) disable iff (rst)
    !lvl && !hit_set |=> !lvl);

endmodule

// File: rtl/oc_guard.sv
module oc_guard
  import pstage_pkg::*;
#(
  parameter int OC_DGL = 125000
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_flag,
  input  logic cyc_start,
  input  logic run_ok,
  input  logic en,
  input  logic sup_good,
  output logic cyc_skip,
  output logic oc_lat
);
  localparam int CW = cnt_w(OC_DGL);

  logic [CW-1:0] run_cnt;
  logic          en_q;
  logic          release_req;
  logic          trip_now;

  assign release_req = (en && !en_q) || !sup_good;
  assign trip_now    = run_ok && oc_flag && (run_cnt == CW'(OC_DGL - 1));

  // Valley limit: deny the requested period while current is high
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_skip <= 1'b0;
    end else begin
      cyc_skip <= cyc_start && oc_flag;
    end
  end

  // Persistence counter for the over-current flag
  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (!run_ok || !oc_flag || oc_lat) begin
      run_cnt <= '0;
    end else if (run_cnt != CW'(OC_DGL - 1)) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // Shutdown latch, release has priority over a new trip
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      oc_lat <= 1'b0;
    end else begin
      en_q <= en;
      if (release_req) begin
        oc_lat <= 1'b0;
      end else if (trip_now) begin
        oc_lat <= 1'b1;
      end
    end
  end

  // R6: a start request with high current is denied
  a_r6_skip_set: assert property (@(posedge clk) disable iff (rst)
    cyc_start && oc_flag |=> cyc_skip);
  // R6: no denial without both conditions
  a_r6_skip_clr: assert property (@(posedge clk) disable iff (rst)
    !(cyc_start && oc_flag) |=> !cyc_skip);
  // R7: a low flag sample never sets the latch
  a_r7_no_trip_low: assert property (@(posedge clk) disable iff (rst)
    !oc_lat && !oc_flag |=> !oc_lat);
  // R8: the latch holds until a release condition appears
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    oc_lat && en && en_q && sup_good |=> oc_lat);

endmodule

// File: rtl/pstage_guard.sv
module pstage_guard
  import pstage_pkg::*;
#(
  parameter int VW     = 8,
  parameter int TW     = 8,
  parameter int V_ON   = 200,
  parameter int V_HYS  = 5,
  parameter int V_DGL  = 16,
  parameter int T_TRIP = 145,
  parameter int T_HYS  = 45,
  parameter int OC_DGL = 125000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [VW-1:0] vsup_code,
  input  logic [TW-1:0] tj_code,
  input  logic          oc_flag,
  input  logic          en,
  input  logic          cyc_start,
  output logic          run_ok,
  output logic          cyc_skip,
  output logic          oc_latched,
  output logic          fault_oe
);
  localparam int V_CLR  = V_ON - V_HYS - 1;   // last code counted as low
  localparam int T_SET  = T_TRIP + 1;         // first code counted as hot
  localparam int T_CLR  = T_TRIP - T_HYS;     // highest code that re-arms

  health_t hs;
  logic    oc_lat;

  hyst_det #(
    .W(VW), .SET_AT(V_ON), .CLR_AT(V_CLR), .DGL(V_DGL)
  ) u_sup (
    .clk(clk), .rst(rst), .x(vsup_code), .lvl(hs.sup_good)
  );

  hyst_det #(
    .W(TW), .SET_AT(T_SET), .CLR_AT(T_CLR), .DGL(1)
  ) u_therm (
    .clk(clk), .rst(rst), .x(tj_code), .lvl(hs.hot)
  );

  oc_guard #(
    .OC_DGL(OC_DGL)
  ) u_oc (
    .clk(clk), .rst(rst), .oc_flag(oc_flag), .cyc_start(cyc_start),
    .run_ok(run_ok), .en(en), .sup_good(hs.sup_good),
    .cyc_skip(cyc_skip), .oc_lat(oc_lat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_ok <= 1'b0;
    end else begin
      run_ok <= hs.sup_good && !hs.hot && !oc_lat && en;
    end
  end

  assign oc_latched = oc_lat;
  assign fault_oe   = oc_lat;

  // R5: enable low removes run permission on the next edge
  a_r5_en_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !run_ok);
  // R4: over-temperature removes run permission
  a_r4_hot_off: assert property (@(posedge clk) disable iff (rst)
    hs.hot |=> !run_ok);
  // R8: a latched over-current removes run permission
  a_r8_lat_off: assert property (@(posedge clk) disable iff (rst)
    oc_latched |=> !run_ok);
  // R3: a bad supply removes run permission
  a_r3_sup_off: assert property (@(posedge clk) disable iff (rst)
    !hs.sup_good |=> !run_ok);

endmodule

// File: tb/pstage_guard_tb_top.sv
`timescale 1ns/1ps
module pstage_guard_tb_top;
  localparam int VW = 8, TW = 8;
  localparam int V_ON = 200, V_HYS = 5, V_DGL = 4;
  localparam int T_TRIP = 145, T_HYS = 45, OC_DGL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [VW-1:0] vsup_code = '0;
  logic [TW-1:0] tj_code = '0;
  logic oc_flag = 1'b0, en = 1'b0, cyc_start = 1'b0;
  logic run_ok, cyc_skip, oc_latched, fault_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pstage_guard #(
    .VW(VW), .TW(TW), .V_ON(V_ON), .V_HYS(V_HYS), .V_DGL(V_DGL),
    .T_TRIP(T_TRIP), .T_HYS(T_HYS), .OC_DGL(OC_DGL)
  ) dut_i (
    .clk(clk), .rst(rst), .vsup_code(vsup_code), .tj_code(tj_code),
    .oc_flag(oc_flag), .en(en), .cyc_start(cyc_start),
    .run_ok(run_ok), .cyc_skip(cyc_skip), .oc_latched(oc_latched),
    .fault_oe(fault_oe)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  initial begin
    step(1);
    // R1: reset state with every input pushing the other way
    vsup_code = 8'd255; en = 1'b1; oc_flag = 1'b1; cyc_start = 1'b1;
    step(3);
    chk("R1 run_ok", run_ok, 1'b0);
    chk("R1 cyc_skip", cyc_skip, 1'b0);
    chk("R1 oc_latched", oc_latched, 1'b0);
    chk("R1 fault_oe", fault_oe, 1'b0);
    vsup_code = 8'd0; oc_flag = 1'b0; cyc_start = 1'b0;
    rst = 1'b0;
    step(1);
    chk("R1 run_ok first cycle", run_ok, 1'b0);
    chk("R1 latch first cycle", oc_latched, 1'b0);

    // R2: latency of supply rise
    vsup_code = 8'd220;
    step(1);
    chk("R2 run_ok one cycle", run_ok, 1'b0);
    step(1);
    chk("R2 run_ok two cycles", run_ok, 1'b1);

    // R2: rising threshold sweep
    for (int c = 0; c < 256; c++) begin
      vsup_code = 8'd0;
      step(6);
      vsup_code = 8'(c);
      step(2);
      chk($sformatf("R2 rise code=%0d", c), run_ok, logic'(c >= V_ON));
    end

    // R3: falling threshold sweep from the good state
    for (int c = 0; c < 256; c++) begin
      vsup_code = 8'd255;
      step(2);
      vsup_code = 8'(c);
      step(6);
      chk($sformatf("R3 fall code=%0d", c), run_ok, logic'(c >= V_ON - V_HYS));
    end

    // R3: filter length boundary
    vsup_code = 8'd220;
    step(3);
    vsup_code = 8'd194;
    step(V_DGL - 1);
    vsup_code = 8'd220;
    step(2);
    chk("R3 short dip ignored", run_ok, 1'b1);
    vsup_code = 8'd194;
    step(V_DGL);
    chk("R3 run_ok before loss", run_ok, 1'b1);
    step(1);
    chk("R3 run_ok after loss", run_ok, 1'b0);
    vsup_code = 8'd220;
    step(3);

    // R4: trip threshold sweep
    for (int c = 0; c < 256; c++) begin
      tj_code = 8'(c);
      step(2);
      chk($sformatf("R4 trip code=%0d", c), run_ok, logic'(c <= T_TRIP));
      tj_code = 8'd0;
      step(2);
    end

    // R4: re-arm threshold sweep
    for (int c = 0; c < 256; c++) begin
      tj_code = 8'd255;
      step(2);
      tj_code = 8'(c);
      step(2);
      chk($sformatf("R4 rearm code=%0d", c), run_ok, logic'(c <= T_TRIP - T_HYS));
      tj_code = 8'd0;
      step(2);
    end

    // R5: enable timing
    en = 1'b0;
    step(1);
    chk("R5 en low", run_ok, 1'b0);
    en = 1'b1;
    step(1);
    chk("R5 en high", run_ok, 1'b1);

    // R6: all strobe/flag combinations
    for (int k = 0; k < 4; k++) begin
      cyc_start = k[0];
      oc_flag   = k[1];
      step(1);
      chk($sformatf("R6 combo=%0d", k), cyc_skip, logic'(k == 3));
      cyc_start = 1'b0;
      oc_flag   = 1'b0;
      step(1);
      chk($sformatf("R6 clear combo=%0d", k), cyc_skip, 1'b0);
    end

    // R7: one sample short of the filter
    step(2);
    oc_flag = 1'b1;
    step(OC_DGL - 1);
    oc_flag = 1'b0;
    step(2);
    chk("R7 short run no latch", oc_latched, 1'b0);
    chk("R7 short run still running", run_ok, 1'b1);

    // R7 / R9: exact filter length
    oc_flag = 1'b1;
    step(OC_DGL - 1);
    chk("R7 latch before last", oc_latched, 1'b0);
    step(1);
    chk("R7 latch on last", oc_latched, 1'b1);
    chk("R9 fault_oe set", fault_oe, 1'b1);
    step(1);
    chk("R8 run_ok dropped", run_ok, 1'b0);

    // R8: hold regardless of flag and enable low
    oc_flag = 1'b0;
    step(10);
    chk("R8 hold flag low", oc_latched, 1'b1);
    en = 1'b0;
    step(3);
    chk("R8 hold en low", oc_latched, 1'b1);
    chk("R9 fault_oe hold", fault_oe, 1'b1);
    en = 1'b1;
    step(1);
    chk("R8 release on en rise", oc_latched, 1'b0);
    chk("R9 fault_oe released", fault_oe, 1'b0);
    step(1);
    chk("R8 run_ok back", run_ok, 1'b1);

    // R8: release through supply loss
    oc_flag = 1'b1;
    step(OC_DGL);
    oc_flag = 1'b0;
    chk("R8 relatch", oc_latched, 1'b1);
    vsup_code = 8'd0;
    step(V_DGL);
    chk("R8 still latched at supply loss", oc_latched, 1'b1);
    step(1);
    chk("R8 release on supply loss", oc_latched, 1'b0);
    chk("R9 fault_oe after supply loss", fault_oe, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule